// File: doc/BRIEF.md
# Single-Wire Token Host Engine

This block is the host end of a half-duplex, single-wire link whose line idles high and is pulled low by either side through an open-drain driver. Every logical bit on the link is one 8N1 UART character, sent or received at 230.4 kbaud. The host issues two kinds of command. A wake command holds the line low for a long, programmable stretch and then leaves it idle. A byte command sends eight bit-characters, least-significant bit first. The host builds flag bytes and count/packet/checksum blocks out of byte commands.

A byte command marked as the last one of a transmission turns the link around. Once its final character has gone out, the engine starts to listen. It decodes each incoming character by counting the falling edges inside a fixed window. It then packs the decoded bits, least-significant first, into bytes. While the host is sending, or while it has not yet turned the link around, any activity on the line is ignored. This includes the host's own echo. Any new command closes the receiver again.

Top module: `swt_host`

## Requirements
- R1: Every bit slot on the wire lasts CLKS_PER_BAUD clocks. The default of 217 at a 50 MHz clock gives 230.4 kbaud within 1 percent.
- R2: A byte command sends eight characters, bit 0 first. Each character has ten slots: a low start slot, eight data slots sent LSB first, and a high stop slot. The data value is 8'hFF for a logical one and 8'hFD for a logical zero. The start slot begins in the clock after the command is accepted, and the next character follows with no gap.
- R3: A wake command pulls the line low for exactly WAKE_BAUDS slots. It then releases the line for IDLE_BAUDS slots before the next command can be accepted.
- R4: A command is accepted when cmd_valid and cmd_ready are both high. cmd_ready stays low from acceptance until the wake gap or the last character of the byte has ended.
- R5: From reset, and from every accepted command until the final character of a byte sent with cmd_last has ended, the receiver is closed. Line activity in that time produces neither rx_valid nor rx_err.
- R6: Once the receiver is open, each character is decoded as follows. A single falling edge inside the window means 1, and two or more falling edges mean 0. Bits fill the byte LSB first. After the eighth bit, rx_valid is high for one clock with the byte on rx_data.
- R7: Device characters whose slot length is off by one sixteenth in either direction still decode correctly when they are sent back to back.
- R8: The window closes 37*CLKS_PER_BAUD/4 clocks after the start edge. A character fails if the line is still low when the window closes, or if it shows more than MAX_PULSES falling edges. On failure, rx_err is high for one clock, the bit is dropped, and the partial byte is discarded.
- R9: After reset, cmd_ready is 1, line_drive_low is 0, rx_valid and rx_err are 0, and the receiver is closed.
- R10: Accepting any command discards a partially received byte, so a later response starts a fresh byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command will be taken |
| cmd_wake | input | 1 | Command is a wake pulse (cmd_data ignored) |
| cmd_last | input | 1 | Byte ends the transmission; receive follows |
| cmd_data | input | 8 | Byte to send, bit 0 first |
| rx_valid | output | 1 | One-clock strobe for a received byte |
| rx_data | output | 8 | Received byte |
| rx_err | output | 1 | One-clock strobe for a malformed character |
| line_in | input | 1 | Sensed wire level |
| line_drive_low | output | 1 | Open-drain enable: 1 pulls the wire low |

## Verification
A bad slot counter or token index in the transmitter shows at the wire within one character. The stretched or shifted slot, or the wrong token pattern, turns into a wrong decoded bit or a wrong period, about ten slots after acceptance. A receiver left open by mistake shows up as a spurious byte once the echo of eight characters has passed. If it is left open by mistake while a partial byte was pending, the next full response comes out with stale bits mixed in. A window counter that is too long or too short breaks back-to-back decoding with drifted device timing on the first pair of characters.

// File: rtl/swt_pkg.sv
package swt_pkg;

    localparam logic [7:0] ONE_CHAR  = 8'hFF;
    localparam logic [7:0] ZERO_CHAR = 8'hFD;
    localparam int         FRAME_SLOTS = 10;
    localparam int         BITS_PER_BYTE = 8;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_WAKE,
        TX_GAP,
        TX_CHAR
    } tx_state_e;

    typedef enum logic {
        RX_HUNT,
        RX_WIN
    } rx_state_e;

    typedef struct packed {
        logic       wake;
        logic       last;
        logic [7:0] data;
    } cmd_t;

    // Full 8N1 frame, slot 0 (start) in bit 0.
    function automatic logic [9:0] token_frame(input logic b);
        return {1'b1, (b ? ONE_CHAR : ZERO_CHAR), 1'b0};
    endfunction

endpackage

// File: rtl/swt_baud.sv
module swt_baud #(
    parameter int DIV = 217
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R1: slot ticks never come on adjacent clocks
    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr) |=> !tick);

endmodule

// File: rtl/swt_tx.sv
module swt_tx
    import swt_pkg::*;
#(
    parameter int CLKS_PER_BAUD = 217,
    parameter int WAKE_BAUDS    = 14,
    parameter int IDLE_BAUDS    = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_valid,
    output logic cmd_ready,
    input  cmd_t cmd,
    output logic drive_low,
    output logic turn_rx
);
    localparam int HOLD_MAX = (WAKE_BAUDS > IDLE_BAUDS) ? WAKE_BAUDS : IDLE_BAUDS;
    localparam int HW       = $clog2(HOLD_MAX + 1);

    tx_state_e  state;
    logic [9:0] frame;
    logic [3:0] slot;
    logic [2:0] tok;
    logic [7:0] pend;
    logic       last_r;
    logic [HW-1:0] hold;
    logic       tick;
    logic       accept;

    assign cmd_ready = (state == TX_IDLE);
    assign accept    = cmd_valid && cmd_ready;

    swt_baud #(.DIV(CLKS_PER_BAUD)) u_baud (
        .clk (clk),
        .rst (rst),
        .clr (accept),
        .tick(tick)
    );

    assign drive_low = (state == TX_WAKE) || ((state == TX_CHAR) && !frame[0]);
    assign turn_rx   = (state == TX_CHAR) && tick && (slot == 4'(FRAME_SLOTS - 1))
                       && (tok == 3'(BITS_PER_BYTE - 1)) && last_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            frame  <= '1;
            slot   <= '0;
            tok    <= '0;
            pend   <= '0;
            last_r <= 1'b0;
            hold   <= '0;
        end else begin
            case (state)
                TX_IDLE: if (accept) begin
                    slot <= '0;
                    tok  <= '0;
                    hold <= '0;
                    if (cmd.wake) begin
                        state  <= TX_WAKE;
                        last_r <= 1'b0;
                    end else begin
                        state  <= TX_CHAR;
                        pend   <= cmd.data;
                        frame  <= token_frame(cmd.data[0]);
                        last_r <= cmd.last;
                    end
                end
                TX_WAKE: if (tick) begin
                    if (hold == HW'(WAKE_BAUDS - 1)) begin
                        state <= TX_GAP;
                        hold  <= '0;
                    end else begin
                        hold <= hold + 1'b1;
                    end
                end
                TX_GAP: if (tick) begin
                    if (hold == HW'(IDLE_BAUDS - 1))
                        state <= TX_IDLE;
                    else
                        hold <= hold + 1'b1;
                end
                TX_CHAR: if (tick) begin
                    if (slot == 4'(FRAME_SLOTS - 1)) begin
                        slot <= '0;
                        if (tok == 3'(BITS_PER_BYTE - 1)) begin
                            state <= TX_IDLE;
                            frame <= '1;
                        end else begin
                            tok   <= tok + 1'b1;
                            pend  <= {1'b0, pend[7:1]};
                            frame <= token_frame(pend[1]);
                        end
                    end else begin
                        slot  <= slot + 1'b1;
                        frame <= {1'b1, frame[9:1]};
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // R2: the start slot (or wake low) begins right after acceptance
    a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> drive_low);

    // R4: never ready while pulling the wire
    a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        drive_low |-> !cmd_ready);

    // R4: turnaround ends the transmission and frees the command port
    a_r4_ready_after_turn: assert property (@(posedge clk) disable iff (rst)
        turn_rx |=> (cmd_ready && !drive_low));

endmodule

// File: rtl/swt_rx.sv
module swt_rx
    import swt_pkg::*;
#(
    parameter int CLKS_PER_BAUD = 217,
    parameter int MAX_PULSES    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en,
    input  logic       line_in,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_err
);
    localparam int WIN = (37 * CLKS_PER_BAUD) / 4;
    localparam int WW  = $clog2(WIN + 1);
    localparam int PW  = $clog2(MAX_PULSES + 2);

    logic [2:0]    sync;
    logic          fall;
    logic          level;
    rx_state_e     state;
    logic [WW-1:0] wcnt;
    logic [PW-1:0] pulses;
    logic [7:0]    shreg;
    logic [2:0]    nbits;
    logic          bit_val;
    logic          bad;

    assign level   = sync[1];
    assign fall    = sync[2] && !sync[1];
    assign bit_val = (pulses == PW'(1));
    assign bad     = !level || (pulses > PW'(MAX_PULSES));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync     <= '1;
            state    <= RX_HUNT;
            wcnt     <= '0;
            pulses   <= '0;
            shreg    <= '0;
            nbits    <= '0;
            rx_valid <= 1'b0;
            rx_err   <= 1'b0;
            rx_data  <= '0;
        end else begin
            sync     <= {sync[1:0], line_in};
            rx_valid <= 1'b0;
            rx_err   <= 1'b0;
            if (!rx_en) begin
                state <= RX_HUNT;
                nbits <= '0;
            end else begin
                case (state)
                    RX_HUNT: if (fall) begin
                        state  <= RX_WIN;
                        wcnt   <= '0;
                        pulses <= PW'(1);
                    end
                    RX_WIN: begin
                        wcnt <= wcnt + 1'b1;
                        if (fall && (pulses <= PW'(MAX_PULSES)))
                            pulses <= pulses + 1'b1;
                        if (wcnt == WW'(WIN - 1)) begin
                            state <= RX_HUNT;
                            if (bad) begin
                                rx_err <= 1'b1;
                                nbits  <= '0;
                            end else begin
                                shreg <= {bit_val, shreg[7:1]};
                                if (nbits == 3'(BITS_PER_BYTE - 1)) begin
                                    rx_valid <= 1'b1;
                                    rx_data  <= {bit_val, shreg[7:1]};
                                    nbits    <= '0;
                                end else begin
                                    nbits <= nbits + 1'b1;
                                end
                            end
                        end
                    end
                    default: state <= RX_HUNT;
                endcase
            end
        end
    end

    // R5: a closed receiver reports nothing
    a_r5_quiet_when_closed: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (!rx_valid && !rx_err));

    // R6: a byte needs eight characters, so strobes never repeat back to back
    a_r6_valid_spaced: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R8: error and data strobes are exclusive
    a_r8_err_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rx_valid, rx_err}));

endmodule

// File: rtl/swt_host.sv
module swt_host
    import swt_pkg::*;
#(
    parameter int CLKS_PER_BAUD = 217,
    parameter int WAKE_BAUDS    = 14,
    parameter int IDLE_BAUDS    = 8,
    parameter int MAX_PULSES    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic       cmd_wake,
    input  logic       cmd_last,
    input  logic [7:0] cmd_data,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_err,
    input  logic       line_in,
    output logic       line_drive_low
);
    cmd_t cmd;
    logic turn_rx;
    logic rx_en;

    assign cmd = '{wake: cmd_wake, last: cmd_last, data: cmd_data};

    swt_tx #(
        .CLKS_PER_BAUD(CLKS_PER_BAUD),
        .WAKE_BAUDS   (WAKE_BAUDS),
        .IDLE_BAUDS   (IDLE_BAUDS)
    ) u_tx (
        .clk      (clk),
        .rst      (rst),
        .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready),
        .cmd      (cmd),
        .drive_low(line_drive_low),
        .turn_rx  (turn_rx)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rx_en <= 1'b0;
        else if (cmd_valid && cmd_ready)
            rx_en <= 1'b0;
        else if (turn_rx)
            rx_en <= 1'b1;
    end

    swt_rx #(
        .CLKS_PER_BAUD(CLKS_PER_BAUD),
        .MAX_PULSES   (MAX_PULSES)
    ) u_rx (
        .clk     (clk),
        .rst     (rst),
        .rx_en   (rx_en),
        .line_in (line_in),
        .rx_valid(rx_valid),
        .rx_data (rx_data),
        .rx_err  (rx_err)
    );

    // R5: receiver is never open while the host pulls the wire
    a_r5_no_listen_while_driving: assert property (@(posedge clk) disable iff (rst)
        line_drive_low |-> !rx_en);

    // R10: a fresh command always closes the receiver
    a_r10_cmd_closes_rx: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !rx_en);

endmodule

// File: tb/swt_host_test.sv
module swt_host_test;
    localparam int N    = 16;
    localparam int WK   = 14;
    localparam int IDL  = 10;
    localparam real TCK = 20.0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic       cmd_wake = 1'b0;
    logic       cmd_last = 1'b0;
    logic [7:0] cmd_data = 8'h00;
    logic       cmd_ready;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_err;
    logic       line_drive_low;
    logic       dev_low = 1'b0;
    logic       line_in;

    assign line_in = !(line_drive_low || dev_low);

    always #10 clk = !clk;

    swt_host #(
        .CLKS_PER_BAUD(N),
        .WAKE_BAUDS   (WK),
        .IDLE_BAUDS   (IDL),
        .MAX_PULSES   (4)
    ) uut (
        .clk           (clk),
        .rst           (rst),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_wake      (cmd_wake),
        .cmd_last      (cmd_last),
        .cmd_data      (cmd_data),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data),
        .rx_err        (rx_err),
        .line_in       (line_in),
        .line_drive_low(line_drive_low)
    );

    int         checks = 0;
    int         errors = 0;
    int         rx_events = 0;
    int         err_events = 0;
    logic [7:0] exp_tx[$];
    logic [7:0] exp_rx[$];
    logic       mon_tx_on = 1'b0;
    string      rx_req = "R6";
    logic       done = 1'b0;

    task automatic check(input logic ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Receive-side scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                rx_events++;
                if (exp_rx.size() == 0) begin
                    check(1'b0, "R5", "unexpected received byte", rx_data, -1);
                end else begin
                    automatic logic [7:0] e = exp_rx.pop_front();
                    check(rx_data == e, rx_req, "received byte", rx_data, e);
                end
            end
            if (rx_err) err_events++;
        end
    end

    // Wire-side monitor: decodes host characters and times the slots
    initial begin
        automatic int   tok_i = 0;
        automatic logic [7:0] acc = 8'h00;
        automatic realtime t_prev = 0;
        forever begin
            @(negedge clk);
            if (mon_tx_on && line_drive_low) begin
                automatic realtime t0 = $realtime;
                automatic logic [9:0] fr;
                for (int k = 0; k < 10; k++) begin
                    if (k == 0) repeat (N / 2) @(negedge clk);
                    else        repeat (N) @(negedge clk);
                    fr[k] = !line_drive_low;
                end
                // R2: start low, stop high, data 8'hFF (one) or 8'hFD (zero)
                check(fr[0] == 1'b0 && fr[9] == 1'b1, "R2", "frame start/stop", fr, 10'h3FE);
                check(fr[8:1] == 8'hFF || fr[8:1] == 8'hFD, "R2", "token pattern", fr[8:1], 8'hFF);
                if (tok_i > 0) begin
                    automatic real per = (t0 - t_prev) / 10.0;
                    automatic real want = N * TCK;
                    // R1: slot period within 1 percent
                    check((per - want) <= 0.01 * want && (want - per) <= 0.01 * want,
                          "R1", "slot period ps", longint'(per * 1000.0), longint'(want * 1000.0));
                end
                t_prev = t0;
                acc[tok_i] = (fr[8:1] == 8'hFF);
                tok_i++;
                if (tok_i == 8) begin
                    tok_i = 0;
                    if (exp_tx.size() == 0) begin
                        check(1'b0, "R2", "unexpected transmitted byte", acc, -1);
                    end else begin
                        automatic logic [7:0] e = exp_tx.pop_front();
                        check(acc == e, "R2", "transmitted byte LSB first", acc, e);
                    end
                end
            end
        end
    end

    task automatic host_cmd(input logic wake, input logic [7:0] v, input logic last);
        if (!wake) exp_tx.push_back(v);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_wake  = wake;
        cmd_data  = v;
        cmd_last  = last;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_wake  = 1'b0;
        cmd_last  = 1'b0;
        check(!cmd_ready, "R4", "ready drops after accept", cmd_ready, 0);
        check(line_drive_low, "R2", "wire low right after accept", line_drive_low, 1);
    endtask

    task automatic wait_idle();
        while (!cmd_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic dev_char(input logic b, input int len);
        automatic logic [9:0] fr = b ? 10'b1_11111111_0 : 10'b1_11111101_0;
        for (int k = 0; k < 10; k++) begin
            dev_low = !fr[k];
            repeat (len) @(negedge clk);
        end
        dev_low = 1'b0;
    endtask

    task automatic dev_byte(input logic [7:0] v, input int len, input logic expect_it);
        if (expect_it) exp_rx.push_back(v);
        for (int i = 0; i < 8; i++) dev_char(v[i], len);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int base;
        int cnt;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check(cmd_ready == 1'b1, "R9", "cmd_ready after reset", cmd_ready, 1);
        check(line_drive_low == 1'b0, "R9", "line released after reset", line_drive_low, 0);
        check(!rx_valid && !rx_err, "R9", "no rx strobes after reset", {rx_valid, rx_err}, 0);
        dev_byte(8'h5A, N, 1'b0);
        check(rx_events == 0 && err_events == 0, "R9", "receiver closed after reset", rx_events, 0);

        // R3: wake pulse length and idle gap
        host_cmd(1'b1, 8'h00, 1'b0);
        cnt = 1;
        forever begin
            @(negedge clk);
            if (!line_drive_low) break;
            cnt++;
        end
        check(cnt == WK * N, "R3", "wake low clocks", cnt, WK * N);
        cnt = 1;
        forever begin
            @(negedge clk);
            if (cmd_ready) break;
            cnt++;
        end
        check(cnt == IDL * N, "R3", "post-wake idle clocks", cnt, IDL * N);

        // R2/R1: flag-like and data bytes
        mon_tx_on = 1'b1;
        host_cmd(1'b0, 8'hA5, 1'b0);
        wait_idle();
        host_cmd(1'b0, 8'h3C, 1'b0);
        wait_idle();
        // R5: device activity with the receiver still closed
        dev_byte(8'hE1, N, 1'b0);
        check(rx_events == 0 && err_events == 0, "R5", "closed receiver ignores line", rx_events, 0);
        host_cmd(1'b0, 8'h81, 1'b1);
        wait_idle();
        check(rx_events == 0 && err_events == 0, "R5", "own echo discarded", rx_events, 0);

        // R6: open receiver decodes device characters
        rx_req = "R6";
        dev_byte(8'h6B, N, 1'b1);
        dev_byte(8'h00, N, 1'b1);
        dev_byte(8'hFF, N, 1'b1);
        check(rx_events == 3, "R6", "bytes received", rx_events, 3);

        // R7: drifted device timing, back to back
        rx_req = "R7";
        exp_rx.push_back(8'hC7);
        exp_rx.push_back(8'h18);
        for (int i = 0; i < 8; i++) dev_char(8'hC7 >> i, N + 1);
        for (int i = 0; i < 8; i++) dev_char(8'h18 >> i, N - 1);
        repeat (4) @(negedge clk);
        check(rx_events == 5, "R7", "drifted bytes received", rx_events, 5);

        // R8: framing error discards a partial byte
        rx_req = "R8";
        base = rx_events;
        dev_char(1'b1, N);
        dev_char(1'b0, N);
        dev_char(1'b1, N);
        dev_low = 1'b1;
        repeat (12 * N) @(negedge clk);
        dev_low = 1'b0;
        repeat (2 * N) @(negedge clk);
        check(err_events == 1, "R8", "error strobes", err_events, 1);
        check(rx_events == base, "R8", "no byte on error", rx_events, base);
        dev_byte(8'h42, N, 1'b1);
        check(rx_events == base + 1, "R8", "fresh byte after error", rx_events, base + 1);

        // R10: new command drops a partial byte
        rx_req = "R10";
        for (int i = 0; i < 5; i++) dev_char(1'b0, N);
        repeat (4) @(negedge clk);
        host_cmd(1'b0, 8'h99, 1'b1);
        wait_idle();
        base = rx_events;
        dev_byte(8'h24, N, 1'b1);
        check(rx_events == base + 1, "R10", "one byte after new command", rx_events, base + 1);

        repeat (N) @(negedge clk);
        check(exp_tx.size() == 0, "R2", "all sent bytes seen", exp_tx.size(), 0);
        check(exp_rx.size() == 0, "R6", "all device bytes delivered", exp_rx.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule